// File: doc/BRIEF.md
# Endian-Selectable Long-Word Unpacker

This block sits on the read side of a FIFO that holds 36-bit long words and delivers them through a read port whose width can be set. The port can run at the full 36 bits, at 18 bits (two halves per long word) or at 9 bits (four lanes per long word). A read request consumes one beat. The FIFO is popped only when the last piece of the current long word leaves the port, so a long word produces one, two or four beats depending on the width.

In the narrow modes the order of the pieces depends on an endian bit, which is sampled while master reset is held. In big-endian order the most significant piece comes out first. In little-endian order the least significant piece comes out first. Narrow beats appear on the low bits of the output bus and the bits above them read zero. At full width the endian bit has no effect.

Top module: `lw_unpacker`

## Requirements
- R1: While `rst_n` is low, `pop_o` and `out_valid_o` are both 0 whatever the other inputs are, and the sub-word position returns to the first beat.
- R2: With `width_sel_i` = 2'b00 or 2'b11 (long-word mode), `out_data_o` equals `in_data_i` and every accepted request pops. The endian setting has no effect in this mode.
- R3: In word mode (`width_sel_i` = 2'b01) with little-endian order, the first beat is `in_data_i[17:0]`, the second is `in_data_i[35:18]`, and `out_data_o[35:18]` is zero.
- R4: In word mode with big-endian order, the first beat is `in_data_i[35:18]` and the second is `in_data_i[17:0]`.
- R5: In byte mode (`width_sel_i` = 2'b10) with little-endian order, the beats are lanes 0, 1, 2, 3, where lane n is `in_data_i[9n+8:9n]`, and `out_data_o[35:9]` is zero.
- R6: In byte mode with big-endian order, the beats are lanes 3, 2, 1, 0.
- R7: `pop_o` is 1 only in the cycle where the last beat of the current long word is accepted (`rd_req_i` and `in_valid_i` both 1). The next beat then starts on the first piece of the following long word.
- R8: A request while `in_valid_i` is 0 is ignored. There is no pop and the beat position does not move.
- R9: The endian choice is `big_endian_i` (1 = big, 0 = little) as sampled at the last clock edge with `rst_n` low. Later changes of `big_endian_i` are ignored until the next reset.
- R10: Outside reset, `out_valid_o` equals `in_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset; the endian bit is sampled while it is low |
| big_endian_i | input | 1 | Endian choice: 1 gives most significant piece first |
| width_sel_i | input | 2 | 00/11 long word, 01 word, 10 byte |
| in_data_i | input | 36 | Long word at the FIFO head |
| in_valid_i | input | 1 | FIFO head holds a long word |
| pop_o | output | 1 | Remove the head long word from the FIFO |
| rd_req_i | input | 1 | Read request, one beat per cycle |
| out_data_o | output | 36 | Beat data; narrow beats on the low bits, upper bits zero |
| out_valid_o | output | 1 | A beat is available |

## Verification
The final beat of a long word and the FIFO pop fall in the same cycle. That cycle also decides which piece the next word starts on. The bench provokes this with back-to-back requests across several long words in byte and word modes, and swaps the presented word right after each pop, the way a FIFO would. It judges that the pop appears on exactly that beat and not on earlier ones. It also judges that the next beat is the first piece of the new word in the latched order.

// File: rtl/lw_unpacker.sv
module lw_unpacker #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int HW    = DW / 2,
  localparam int IW    = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          big_endian_i,
  input  logic [1:0]    width_sel_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          pop_o,
  input  logic          rd_req_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o
);

  logic          endian_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [IW-1:0] sel;
  logic          is_byte, is_word, beat, at_last;

  logic [LANE_W-1:0] lane [LANES];
  logic [HW-1:0]     half [2];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = in_data_i[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = in_data_i[h*HW +: HW];
  end

  assign is_byte  = (width_sel_i == 2'b10);
  assign is_word  = (width_sel_i == 2'b01);
  assign last_idx = is_byte ? IW'(LANES - 1) : (is_word ? IW'(1) : '0);
  assign beat     = rst_n & rd_req_i & in_valid_i;
  assign at_last  = (idx_q >= last_idx);
  assign pop_o    = beat & at_last;
  assign sel      = endian_q ? (last_idx - idx_q) : idx_q;
  assign out_valid_o = rst_n & in_valid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      endian_q <= big_endian_i;
      idx_q    <= '0;
    end else if (beat) begin
      idx_q <= at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    out_data_o = '0;
    if (is_byte)      out_data_o[LANE_W-1:0] = lane[sel];
    else if (is_word) out_data_o[HW-1:0]     = half[sel[0]];
    else              out_data_o             = in_data_i;
  end

endmodule

module lw_unpacker_chk #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    width_sel_i,
  input logic          in_valid_i,
  input logic          rd_req_i,
  input logic          pop_o,
  input logic [DW-1:0] out_data_o,
  input logic          out_valid_o,
  input logic          endian_q
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!pop_o && !out_valid_o));

  // R2
  long_pop_each_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((width_sel_i == 2'b00 || width_sel_i == 2'b11) && rd_req_i && in_valid_i) |-> pop_o);

  // R3
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel_i == 2'b01) |-> (out_data_o[DW-1:DW/2] == '0));

  // R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_sel_i == 2'b10) |-> (out_data_o[DW-1:LANE_W] == '0));

  // R7
  pop_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> (rd_req_i && in_valid_i));

  // R8
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |-> !pop_o);

  // R9
  endian_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(endian_q));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o == in_valid_i);

endmodule

bind lw_unpacker lw_unpacker_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .width_sel_i(width_sel_i), .in_valid_i(in_valid_i),
  .rd_req_i(rd_req_i), .pop_o(pop_o), .out_data_o(out_data_o),
  .out_valid_o(out_valid_o), .endian_q(endian_q)
);

// File: tb/lw_unpacker_tb.sv
`timescale 1ns/1ps
module lw_unpacker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [1:0]  width_sel_i = 2'b00;
  logic [35:0] in_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic        rd_req_i = 1'b0;
  logic        pop_o;
  logic [35:0] out_data_o;
  logic        out_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lw_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .width_sel_i(width_sel_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .pop_o(pop_o), .rd_req_i(rd_req_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o)
  );

  // {endian, width, data}
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 2'b00, 36'h9_1234_5678},
    {1'b1, 2'b00, 36'h9_1234_5678},
    {1'b1, 2'b11, 36'hA_BCDE_F012},
    {1'b0, 2'b01, 36'h3_C0F0_A5A5},
    {1'b1, 2'b01, 36'h3_C0F0_A5A5},
    {1'b0, 2'b10, 36'h8_0402_0100},
    {1'b1, 2'b10, 36'h8_0402_0100},
    {1'b1, 2'b10, 36'hF_EDCB_A987}
  };

  function automatic int nbeats(input logic [1:0] w);
    return (w == 2'b10) ? 4 : ((w == 2'b01) ? 2 : 1);
  endfunction

  function automatic logic [35:0] exp_beat(input logic [35:0] d, input logic [1:0] w,
                                           input logic be, input int k);
    int n, l;
    n = nbeats(w);
    l = be ? (n - 1 - k) : k;
    if (w == 2'b10) return {27'b0, d[9*l +: 9]};
    if (w == 2'b01) return {18'b0, d[18*l +: 18]};
    return d;
  endfunction

  function automatic string rtag(input logic [1:0] w, input logic be);
    if (w == 2'b10) return be ? "R6" : "R5";
    if (w == 2'b01) return be ? "R4" : "R3";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic be);
    rst_n = 1'b0;
    big_endian_i = be;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  task automatic run_word(input logic [35:0] d, input logic [1:0] w, input logic be,
                          input string tag);
    int n;
    n = nbeats(w);
    in_data_i = d;
    in_valid_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      rd_req_i = 1'b1;
      #1;
      check(tag, out_data_o, exp_beat(d, w, be, k));
      check("R7", {35'b0, pop_o}, {35'b0, k == n - 1});
      tick();
    end
    rd_req_i = 1'b0;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs quiet even with request and valid present
    rst_n = 1'b0;
    in_valid_i = 1'b1;
    rd_req_i = 1'b1;
    width_sel_i = 2'b00;
    in_data_i = 36'h1_1111_1111;
    repeat (2) tick();
    check("R1", {34'b0, pop_o, out_valid_o}, 36'h0);
    rd_req_i = 1'b0;
    in_valid_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      width_sel_i = VEC[i][37:36];
      do_reset(VEC[i][38]);
      tick();
      run_word(VEC[i][35:0], VEC[i][37:36], VEC[i][38], rtag(VEC[i][37:36], VEC[i][38]));
    end

    // R8: request with no valid is ignored
    width_sel_i = 2'b10;
    do_reset(1'b0);
    in_valid_i = 1'b0;
    in_data_i = 36'h7_6543_2101;
    rd_req_i = 1'b1;
    #1;
    check("R8", {35'b0, pop_o}, 36'h0);
    tick();
    tick();
    run_word(36'h7_6543_2101, 2'b10, 1'b0, "R8");

    // R10: valid follows input
    in_valid_i = 1'b0;
    #1;
    check("R10", {35'b0, out_valid_o}, 36'h0);
    in_valid_i = 1'b1;
    #1;
    check("R10", {35'b0, out_valid_o}, 36'h1);

    // R9: change of endian input after reset is ignored
    width_sel_i = 2'b01;
    do_reset(1'b1);
    tick();
    big_endian_i = 1'b0;
    tick();
    run_word(36'h5_5555_0000 | 36'h1234, 2'b01, 1'b1, "R9");

    // R7: back-to-back words with continuous requests, byte mode, big-endian
    width_sel_i = 2'b10;
    do_reset(1'b1);
    for (int w = 0; w < 3; w++) begin
      logic [35:0] d;
      d = {4'h0, 32'(w * 32'h1111_1111 + 32'h0102_0304)} ^ {w[3:0], 32'h0};
      in_data_i = d;
      in_valid_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
        rd_req_i = 1'b1;
        #1;
        check("R7", out_data_o, exp_beat(d, 2'b10, 1'b1, k));
        check("R7", {35'b0, pop_o}, {35'b0, k == 3});
        tick();
      end
    end
    rd_req_i = 1'b0;

    // R7: word mode, little-endian, back-to-back
    width_sel_i = 2'b01;
    do_reset(1'b0);
    for (int w = 0; w < 2; w++) begin
      logic [35:0] d;
      d = (w == 0) ? 36'hA_AAAA_5555 : 36'h0_F0F0_0F0F;
      in_data_i = d;
      in_valid_i = 1'b1;
      for (int k = 0; k < 2; k++) begin
        rd_req_i = 1'b1;
        #1;
        check("R7", out_data_o, exp_beat(d, 2'b01, 1'b0, k));
        check("R7", {35'b0, pop_o}, {35'b0, k == 1});
        tick();
      end
    end
    rd_req_i = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule